// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt requests for a small CPU. There is one non-maskable edge input, a set of external request lines and a set of on-chip peripheral event lines. Each maskable line has its own enable bit and a sticky request flag, and both are reachable through a small register port. On every cycle a fixed-priority encoder picks the most urgent eligible request. A maskable request is eligible only while the global interrupt mask is clear. The non-maskable request is always eligible.

The CPU raises an instruction-boundary strobe whenever it could take an interrupt. If a request is eligible on that cycle, the block raises `int_accept`, sets the mask bit, and presents a vector address for the chosen source. It holds both until the CPU acknowledges. Requests that lose arbitration stay latched. The CPU reloads the mask bit through a restore strobe, which models the condition-register load on return from an interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_accept` is 0, `i_mask` is 1, and the enable register and the flag register both read 0.
- R2: The enable register is at `reg_addr`=0. Bit i enables external line i, and bit N_EXT+j enables internal line j. A write loads it, and a read returns it. An event on a disabled line does not set its flag.
- R3: An event on an enabled line sets its flag, which is at `reg_addr`=1 with the same bit layout. The flag stays set until software writes 1 to that bit. Writing 0 bits has no effect. An event in the same cycle as a clearing write leaves the flag set.
- R4: Priority is fixed. The non-maskable request comes first, then external lines with the lowest index first, then internal lines with the lowest index first. A flag whose enable bit is 0 takes no part in arbitration but stays readable.
- R5: A maskable request is accepted only while `i_mask` is 0. While `i_mask` is 1 it stays pending.
- R6: A rising edge on `nmi_in` latches a non-maskable request. That request is accepted regardless of `i_mask`, and its latch clears on acceptance. A level that stays high does not raise a second request.
- R7: `int_accept` rises only on the clock edge that samples `insn_boundary` high with an eligible request.
- R8: `i_mask` becomes 1 on the same edge on which `int_accept` rises.
- R9: `int_vector` equals VEC_BASE + 2×source. Source 0 is the non-maskable request, source 1+i is external line i, and source 1+N_EXT+j is internal line j. `int_vector` and `int_accept` hold until `int_ack` is sampled high, and `int_accept` falls on that edge. No new acceptance happens while `int_accept` is high.
- R10: `ccr_load` loads `ccr_i` into `i_mask`. An acceptance on the same edge takes precedence and leaves the mask at 1.
- R11: Acceptance does not clear maskable flags. Requests that were not selected remain pending and are served later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, edge detected |
| ext_evt | input | N_EXT | External request events |
| int_evt | input | N_INT | Internal peripheral events |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable register, 1 = flag register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| insn_boundary | input | 1 | Instruction-boundary strobe |
| int_ack | input | 1 | CPU acknowledge of the vector |
| ccr_load | input | 1 | Mask restore strobe |
| ccr_i | input | 1 | Value restored into the mask |
| int_accept | output | 1 | Interrupt accepted, vector valid |
| int_vector | output | VEC_W | Vector address of accepted source |
| i_mask | output | 1 | Global interrupt mask bit |

## Verification
A corrupted flag or enable bit shows up at once on a register read. On the next boundary strobe it also shows up as a wrong or missing vector. A wrong mask state appears on `i_mask` on the edge that caused it. A request that was dropped by mistake surfaces as a missing acceptance at the next strobe after its competitor is acknowledged. A vector that drifts during a hold is visible on the first cycle it changes before the acknowledge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [0:0] {SEL_ENABLE = 1'b0, SEL_FLAG = 1'b1} reg_sel_e;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_HOLD = 1'b1} acc_state_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank import prio_irq_pkg::*; #(
  parameter int M      = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [M-1:0]      evt,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [M-1:0]      wdata,
  output logic [M-1:0]      en_q,
  output logic [M-1:0]      flag_q,
  output logic [DATA_W-1:0] rdata
);
  logic         en_ld;
  logic [M-1:0] clr_v;
  logic [M-1:0] flag_d;
  logic [M-1:0] rd_v;

  always_comb begin
    en_ld = reg_we && (reg_addr == SEL_ENABLE);
    clr_v = (reg_we && (reg_addr == SEL_FLAG)) ? wdata : '0;
    // a new event wins over a clear in the same cycle
    flag_d = (flag_q & ~clr_v) | (evt & en_q);
    rd_v   = (reg_addr == SEL_FLAG) ? flag_q : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ld) en_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  generate
    if (DATA_W > M) begin : g_pad
      assign rdata = {{(DATA_W-M){1'b0}}, rd_v};
    end else begin : g_nopad
      assign rdata = rd_v;
    end
  endgenerate

  generate
    for (genvar g = 0; g < M; g++) begin : g_chk
      // R3: a flag stays set until its bit is written with 1
      p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[g] && !clr_v[g]) |=> flag_q[g]);
      // R2: a disabled, clear flag cannot become set
      p_flag_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[g] && !en_q[g]) |=> !flag_q[g]);
    end
  endgenerate
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend_q
);
  logic nmi_q;
  logic rise;
  logic pend_d;

  always_comb begin
    rise   = nmi_in && !nmi_q;
    pend_d = rise || (pend_q && !take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_in;
      pend_q <= pend_d;
    end
  end

  // R6: the latched request survives until it is taken
  p_nmi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> pend_q);
  // R6: a steady high level never re-arms the latch
  p_nmi_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && nmi_q && nmi_in) |=> !pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 13,
  parameter int SRC_W = 4
) (
  input  logic [NSRC-1:0]  req,
  output logic             any,
  output logic [SRC_W-1:0] sel
);
  // lowest index wins; index 0 is the non-maskable source
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        sel = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_accept_fsm.sv
module irq_accept_fsm import prio_irq_pkg::*; #(
  parameter int               SRC_W    = 4,
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [SRC_W-1:0] sel,
  input  logic             boundary,
  input  logic             ack,
  input  logic             ccr_load,
  input  logic             ccr_i,
  output logic             accept,
  output logic [VEC_W-1:0] vec_q,
  output logic             imask_q,
  output logic             nmi_take
);
  acc_state_e       state_q, state_d;
  logic             acc_ld;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    state_d = state_q;
    acc_ld  = 1'b0;
    case (state_q)
      ST_IDLE: if (boundary && any) begin
        state_d = ST_HOLD;
        acc_ld  = 1'b1;
      end
      ST_HOLD: if (ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    vec_d    = VEC_BASE + (VEC_W'(sel) << 1);
    nmi_take = acc_ld && (sel == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (acc_ld) vec_q <= vec_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        imask_q <= 1'b1;
    else if (acc_ld)   imask_q <= 1'b1;
    else if (ccr_load) imask_q <= ccr_i;
  end

  assign accept = (state_q == ST_HOLD);

  // R8: mask is set on the accepting edge
  p_mask_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> imask_q);
  // R7: acceptance follows a sampled boundary strobe
  p_needs_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> $past(boundary));
  // R9: vector and accept hold until acknowledged
  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ack) |=> (accept && $stable(vec_q)));
  // R9: acknowledge releases accept on the next edge
  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ack) |=> !accept);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import prio_irq_pkg::*; #(
  parameter int               N_EXT    = 4,
  parameter int               N_INT    = 8,
  parameter int               DATA_W   = 16,
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic [N_EXT-1:0]  ext_evt,
  input  logic [N_INT-1:0]  int_evt,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              insn_boundary,
  input  logic              int_ack,
  input  logic              ccr_load,
  input  logic              ccr_i,
  output logic              int_accept,
  output logic [VEC_W-1:0]  int_vector,
  output logic              i_mask
);
  localparam int M     = N_EXT + N_INT;
  localparam int NSRC  = M + 1;
  localparam int SRC_W = $clog2(NSRC);

  logic             rst_s;
  logic [M-1:0]     evt;
  logic [M-1:0]     en_q;
  logic [M-1:0]     flag_q;
  logic [M-1:0]     live;
  logic [NSRC-1:0]  req_all;
  logic             nmi_pend;
  logic             nmi_take;
  logic             any;
  logic [SRC_W-1:0] sel;

  generate
    if (DATA_W > M) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:M];
    end
  endgenerate

  irq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  assign evt = {int_evt, ext_evt};

  irq_flag_bank #(.M(M), .DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_s),
    .evt      (evt),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wdata    (reg_wdata[M-1:0]),
    .en_q     (en_q),
    .flag_q   (flag_q),
    .rdata    (reg_rdata)
  );

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_s),
    .nmi_in (nmi_in),
    .take   (nmi_take),
    .pend_q (nmi_pend)
  );

  // maskable sources reach arbitration only if enabled and unmasked
  assign live    = flag_q & en_q & {M{~i_mask}};
  assign req_all = {live, nmi_pend};

  irq_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
    .req (req_all),
    .any (any),
    .sel (sel)
  );

  irq_accept_fsm #(.SRC_W(SRC_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s),
    .any      (any),
    .sel      (sel),
    .boundary (insn_boundary),
    .ack      (int_ack),
    .ccr_load (ccr_load),
    .ccr_i    (ccr_i),
    .accept   (int_accept),
    .vec_q    (int_vector),
    .imask_q  (i_mask),
    .nmi_take (nmi_take)
  );

  // R4: no request of lower index is pending beside the selected one
  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_s)
    any |-> (req_all[sel] && ((req_all & ((NSRC'(1) << sel) - NSRC'(1))) == '0)));
  // R5: a maskable acceptance needs a clear mask
  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(int_accept) && (int_vector != VEC_BASE)) |-> !$past(i_mask));
  // R6: a latched non-maskable request is taken at the next idle boundary
  p_nmi_accept_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (nmi_pend && insn_boundary && !int_accept) |=> (int_accept && (int_vector == VEC_BASE)));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int          N_EXT  = 4;
  localparam int          N_INT  = 8;
  localparam int          DATA_W = 16;
  localparam int          VEC_W  = 16;
  localparam logic [15:0] BASE   = 16'h0100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              nmi_in = 1'b0;
  logic [N_EXT-1:0]  ext_evt = '0;
  logic [N_INT-1:0]  int_evt = '0;
  logic              reg_we = 1'b0;
  logic              reg_addr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              insn_boundary = 1'b0;
  logic              int_ack = 1'b0;
  logic              ccr_load = 1'b0;
  logic              ccr_i = 1'b0;
  logic              int_accept;
  logic [VEC_W-1:0]  int_vector;
  logic              i_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.N_EXT(N_EXT), .N_INT(N_INT), .DATA_W(DATA_W),
                  .VEC_W(VEC_W), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .ext_evt(ext_evt), .int_evt(int_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .insn_boundary(insn_boundary), .int_ack(int_ack), .ccr_load(ccr_load), .ccr_i(ccr_i),
    .int_accept(int_accept), .int_vector(int_vector), .i_mask(i_mask));

  // {enable[11:0], event[11:0], expected source[3:0]}; source 15 = no acceptance
  localparam logic [27:0] TABLE [8] = '{
    {12'hFFF, 12'h001, 4'd1},
    {12'hFFF, 12'h0A4, 4'd3},
    {12'hFFF, 12'hF00, 4'd9},
    {12'hFF0, 12'h00F, 4'd15},
    {12'hF0F, 12'h0F8, 4'd4},
    {12'h800, 12'hFFF, 4'd12},
    {12'h000, 12'h000, 4'd15},
    {12'hFFE, 12'h003, 4'd2}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [DATA_W-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [DATA_W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic evt(logic [11:0] e);
    ext_evt = e[3:0]; int_evt = e[11:4];
    @(negedge clk);
    ext_evt = '0; int_evt = '0;
  endtask

  task automatic set_i(logic v);
    ccr_load = 1'b1; ccr_i = v;
    @(negedge clk);
    ccr_load = 1'b0;
  endtask

  task automatic bnd();
    insn_boundary = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0;
  endtask

  task automatic ack();
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi_in = 1'b1;
    @(negedge clk);
    nmi_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 accept", int_accept, 0);
    chk("R1 i_mask", i_mask, 1);
    rd(1'b0, d); chk("R1 enable reg", d, 0);
    rd(1'b1, d); chk("R1 flag reg", d, 0);

    // table walk: priority and vectors (R4, R9, R3)
    for (int k = 0; k < 8; k++) begin
      logic [11:0] en, ev;
      logic [3:0]  src;
      {en, ev, src} = TABLE[k];
      wr(1'b0, {4'h0, en});
      wr(1'b1, 16'hFFFF);
      set_i(1'b0);
      evt(ev);
      rd(1'b1, d); chk("R3 table flags", d, {4'h0, ev & en});
      bnd();
      if (src == 4'd15) begin
        chk("R4 table no accept", int_accept, 0);
      end else begin
        chk("R4 table accept", int_accept, 1);
        chk("R9 table vector", int_vector, BASE + 16'(src) * 2);
        chk("R8 table mask", i_mask, 1);
        ack();
        chk("R9 table release", int_accept, 0);
      end
    end

    // R5 / R10 mask gating
    wr(1'b0, 16'h0FFF);
    wr(1'b1, 16'hFFFF);
    set_i(1'b1);
    chk("R10 mask load 1", i_mask, 1);
    evt(12'h001);
    bnd();
    chk("R5 masked held", int_accept, 0);
    set_i(1'b0);
    chk("R10 mask load 0", i_mask, 0);
    bnd();
    chk("R5 unmasked accept", int_accept, 1);
    chk("R5 vector", int_vector, BASE + 16'd2);
    ack();

    // R6 non-maskable ignores mask, no retrigger on held level
    chk("R8 mask after accept", i_mask, 1);
    nmi_in = 1'b1;
    @(negedge clk);
    bnd();
    chk("R6 nmi accepted masked", int_accept, 1);
    chk("R6 nmi vector", int_vector, BASE);
    ack();
    bnd();
    chk("R6 held level no retrigger", int_accept, 0);
    nmi_in = 1'b0;
    rd(1'b1, d); chk("R11 flag still pending", d, 16'h0001);

    // R4 non-maskable above maskable; R11 loser served later
    set_i(1'b0);
    nmi_pulse();
    bnd();
    chk("R4 nmi over ext0", int_vector, BASE);
    ack();
    set_i(1'b0);
    bnd();
    chk("R11 pending ext0 served", int_vector, BASE + 16'd2);
    ack();

    // R7 no accept without boundary
    set_i(1'b0);
    repeat (3) @(negedge clk);
    chk("R7 no boundary no accept", int_accept, 0);
    bnd();
    chk("R7 boundary accept", int_accept, 1);

    // R9 hold while unacknowledged
    nmi_pulse();
    bnd();
    @(negedge clk);
    chk("R9 accept held", int_accept, 1);
    chk("R9 vector stable", int_vector, BASE + 16'd2);
    ack();
    chk("R9 released", int_accept, 0);
    bnd();
    chk("R6 nmi kept pending during hold", int_vector, BASE);
    chk("R6 nmi accept", int_accept, 1);
    ack();

    // R3 flag clear semantics
    ext_evt = 4'b0001; reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h0001;
    @(negedge clk);
    ext_evt = '0; reg_we = 1'b0;
    rd(1'b1, d); chk("R3 set wins over clear", d, 16'h0001);
    wr(1'b1, 16'h0001);
    rd(1'b1, d); chk("R3 write-1 clears", d, 16'h0000);
    evt(12'h002);
    wr(1'b1, 16'h0000);
    rd(1'b1, d); chk("R3 write-0 no effect", d, 16'h0002);

    // R2 enable register
    wr(1'b0, 16'h0000);
    evt(12'h004);
    rd(1'b1, d); chk("R2 disabled no set", d, 16'h0002);
    rd(1'b0, d); chk("R2 enable reads 0", d, 16'h0000);
    wr(1'b0, 16'h0FFF);
    rd(1'b0, d); chk("R2 enable readback", d, 16'h0FFF);

    // R4 disabled flag excluded but readable
    evt(12'h001);
    wr(1'b0, 16'h0FFE);
    set_i(1'b0);
    bnd();
    chk("R4 disabled flag skipped", int_vector, BASE + 16'd4);
    rd(1'b1, d); chk("R4 disabled flag kept", d, 16'h0003);
    ack();

    // R10 acceptance beats restore on the same edge
    set_i(1'b0);
    insn_boundary = 1'b1; ccr_load = 1'b1; ccr_i = 1'b0;
    @(negedge clk);
    insn_boundary = 1'b0; ccr_load = 1'b0;
    chk("R10 accept on restore edge", int_accept, 1);
    chk("R10 mask stays set", i_mask, 1);
    ack();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule